// File: doc/BRIEF.md
# Instruction-Fetch Execution Guard

This block sits beside a CPU's memory path and decides, for every transaction, whether the CPU gets the read data or something safer. It sees the CPU address, a valid strobe, a flag that marks instruction fetches, and the read data that comes back from memory. It returns the instruction and data word that the CPU actually receives. A fetch that the guard refuses is handed back as an all-zero word. The CPU decodes that word as an illegal opcode and traps on its own, so the guard never raises an interrupt.

Two protections are always on. The first blocks any fetch from a firmware RAM window. The second flags any access that lands in the RAM decode window but beyond the physical RAM size, and zeroes its data. A third protection is under software control. Software loads the first and last addresses of one region and then sets an enable bit. From then on, fetches inside that region are zeroed. The enable cannot be cleared again before reset, and it freezes the two bounds.

A trap indication from the CPU is latched. While it is latched, the block drives a flashing red LED pattern in place of the LED value requested by the normal LED register.

Top module: `fg_guard`

## Requirements
- R1: After reset the enable bit and both bound registers read as zero, and `led_out` equals `led_req`.
- R2: With `reg_cs` high and `reg_we` low, offset 0x61 reads the first bound, offset 0x62 reads the last bound, and offset 0x60 reads the enable in bit 0 with all other bits zero. Any other offset, and any cycle that is not a read, gives zero on `reg_rdata`.
- R3: Writing bit 0 of offset 0x60 as one sets the enable. Once it is set, later writes to offset 0x60 cannot clear it before reset.
- R4: While the enable is set, writes to offsets 0x61 and 0x62 are ignored, and the bounds keep the values they had when the enable was set.
- R5: While the enable is set, a valid fetch whose address lies in first..last (both ends included) returns zero on `cpu_rdata`. A fetch outside that range, or any fetch made before the enable is set, returns `mem_rdata`.
- R6: A valid non-fetch read inside the protected region returns `mem_rdata` unchanged.
- R7: A valid fetch from the firmware RAM window [FW_RAM_BASE, FW_RAM_BASE+FW_RAM_SIZE) returns zero whatever the enable is. A data read from that window passes unchanged.
- R8: `access_violation` is high exactly when `cpu_valid` is high and the address lies in [RAM_BASE+RAM_SIZE, RAM_BASE+RAM_WIN). This holds for fetches and data reads alike, and such an access returns zero on `cpu_rdata`.
- R9: One cycle with `cpu_trap` high latches a trapped state that lasts until reset. From the following clock edge, `led_out[1]` (green) and `led_out[0]` (blue) are zero and `led_out[2]` (red) toggles every 2^FLASH_LOG2 clocks, whatever `led_req` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_cs | input | 1 | Register bus select |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| cpu_valid | input | 1 | CPU transaction valid |
| cpu_fetch | input | 1 | Transaction is an instruction fetch |
| cpu_addr | input | ADDR_W | CPU byte address |
| mem_rdata | input | DATA_W | Read data from memory |
| cpu_rdata | output | DATA_W | Read data delivered to the CPU |
| access_violation | output | 1 | Access beyond physical RAM |
| cpu_trap | input | 1 | CPU reports it has trapped |
| led_req | input | 3 | Normal LED value {red, green, blue} |
| led_out | output | 3 | LED drive {red, green, blue} |

## Verification
The bench builds the block with a 256-byte firmware window at 0x1000, which is aligned and a power of two, so the mask comparator variant is used. The RAM is 4 KiB at 0x4000_0000 inside a 64 KiB decode window, whose non-power-of-two span takes the range comparator variant. These small sizes put both edges of every window, and the first address past physical RAM, within a few directed vectors. FLASH_LOG2 is 3, so the red toggle period of eight clocks can be measured in a handful of cycles after the trap.

// File: rtl/fg_pkg.sv
package fg_pkg;
   // register offsets decoded by the bus fabric
   localparam logic [7:0] OFS_CTRL  = 8'h60;
   localparam logic [7:0] OFS_FIRST = 8'h61;
   localparam logic [7:0] OFS_LAST  = 8'h62;

   // LED lane positions
   localparam int LED_BLUE  = 0;
   localparam int LED_GREEN = 1;
   localparam int LED_RED   = 2;

   typedef enum logic [1:0] {
      CMP_MASK  = 2'd0,
      CMP_RANGE = 2'd1
   } cmp_kind_e;
endpackage

// File: rtl/fg_window.sv
module fg_window #(
   parameter int                ADDR_W = 32,
   parameter logic [ADDR_W-1:0] BASE   = '0,
   parameter logic [ADDR_W-1:0] SIZE   = 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   import fg_pkg::*;

   localparam logic [ADDR_W-1:0] SIZE_M1 = SIZE - 1'b1;
   localparam bit POW2    = ((SIZE & SIZE_M1) == '0);
   localparam bit ALIGNED = ((BASE & SIZE_M1) == '0);
   localparam cmp_kind_e KIND = (POW2 && ALIGNED) ? CMP_MASK : CMP_RANGE;

   generate
      if (SIZE == '0) begin : g_bad
         $error("fg_window: SIZE must be nonzero");
      end
      if (KIND == CMP_MASK) begin : g_mask
         always_comb hit = ((addr & ~SIZE_M1) == BASE);
      end else begin : g_range
         logic [ADDR_W-1:0] off;
         always_comb begin
            off = addr - BASE;
            hit = (addr >= BASE) && (off < SIZE);
         end
      end
   endgenerate
endmodule

// File: rtl/fg_regs.sv
module fg_regs #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int REG_AW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              we,
   input  logic [REG_AW-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              en,
   output logic [ADDR_W-1:0] first,
   output logic [ADDR_W-1:0] last
);
   import fg_pkg::*;

   localparam logic [REG_AW-1:0] A_CTRL  = REG_AW'(OFS_CTRL);
   localparam logic [REG_AW-1:0] A_FIRST = REG_AW'(OFS_FIRST);
   localparam logic [REG_AW-1:0] A_LAST  = REG_AW'(OFS_LAST);

   logic wr;
   assign wr = cs && we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en    <= 1'b0;
         first <= '0;
         last  <= '0;
      end else begin
         if (wr && addr == A_CTRL && wdata[0]) en <= 1'b1;
         if (wr && !en && addr == A_FIRST) first <= wdata[ADDR_W-1:0];
         if (wr && !en && addr == A_LAST)  last  <= wdata[ADDR_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (cs && !we) begin
         unique case (addr)
            A_CTRL:  rdata = DATA_W'(en);
            A_FIRST: rdata = DATA_W'(first);
            A_LAST:  rdata = DATA_W'(last);
            default: rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/fg_flasher.sv
module fg_flasher #(
   parameter int FLASH_LOG2 = 22
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trap_in,
   input  logic [2:0] led_req,
   output logic [2:0] led_out,
   output logic       trap_seen
);
   import fg_pkg::*;

   logic [FLASH_LOG2-1:0] cnt;
   logic                  phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         phase     <= 1'b0;
         trap_seen <= 1'b0;
      end else begin
         cnt <= cnt + FLASH_LOG2'(1);
         if (&cnt)    phase     <= ~phase;
         if (trap_in) trap_seen <= 1'b1;
      end
   end

   always_comb begin
      led_out = led_req;
      if (trap_seen) begin
         led_out            = '0;
         led_out[LED_RED]   = phase;
      end
   end
endmodule

// File: rtl/fg_guard.sv
module fg_guard #(
   parameter int                ADDR_W      = 32,
   parameter int                DATA_W      = 32,
   parameter int                REG_AW      = 8,
   parameter logic [ADDR_W-1:0] FW_RAM_BASE = 32'hD000_0000,
   parameter logic [ADDR_W-1:0] FW_RAM_SIZE = 32'h0000_0800,
   parameter logic [ADDR_W-1:0] RAM_BASE    = 32'h4000_0000,
   parameter logic [ADDR_W-1:0] RAM_SIZE    = 32'h0002_0000,
   parameter logic [ADDR_W-1:0] RAM_WIN     = 32'h4000_0000,
   parameter int                FLASH_LOG2  = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_cs,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              cpu_valid,
   input  logic              cpu_fetch,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              access_violation,
   input  logic              cpu_trap,
   input  logic [2:0]        led_req,
   output logic [2:0]        led_out
);
   localparam logic [ADDR_W-1:0] OOB_BASE = RAM_BASE + RAM_SIZE;
   localparam logic [ADDR_W-1:0] OOB_SIZE = RAM_WIN - RAM_SIZE;

   generate
      if (DATA_W < ADDR_W) begin : g_chk_w
         $error("fg_guard: DATA_W must hold an address");
      end
      if (REG_AW < 7) begin : g_chk_aw
         $error("fg_guard: REG_AW too narrow for register offsets");
      end
      if (FLASH_LOG2 < 1) begin : g_chk_fl
         $error("fg_guard: FLASH_LOG2 must be at least 1");
      end
      if (RAM_SIZE >= RAM_WIN) begin : g_chk_ram
         $error("fg_guard: RAM_WIN must exceed RAM_SIZE");
      end
   endgenerate

   logic              en_q;
   logic [ADDR_W-1:0] first_q;
   logic [ADDR_W-1:0] last_q;
   logic              trap_seen;
   logic              fw_hit;
   logic              oob_hit;
   logic              region_hit;
   logic              block;

   fg_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .cs(reg_cs), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .en(en_q), .first(first_q), .last(last_q)
   );

   fg_window #(
      .ADDR_W(ADDR_W), .BASE(FW_RAM_BASE), .SIZE(FW_RAM_SIZE)
   ) i_fw_win (
      .addr(cpu_addr), .hit(fw_hit)
   );

   fg_window #(
      .ADDR_W(ADDR_W), .BASE(OOB_BASE), .SIZE(OOB_SIZE)
   ) i_oob_win (
      .addr(cpu_addr), .hit(oob_hit)
   );

   fg_flasher #(
      .FLASH_LOG2(FLASH_LOG2)
   ) i_flash (
      .clk(clk), .rst_n(rst_n),
      .trap_in(cpu_trap), .led_req(led_req),
      .led_out(led_out), .trap_seen(trap_seen)
   );

   always_comb begin
      region_hit       = en_q && (cpu_addr >= first_q) && (cpu_addr <= last_q);
      access_violation = cpu_valid && oob_hit;
      block            = access_violation ||
                         (cpu_valid && cpu_fetch && (fw_hit || region_hit));
      cpu_rdata        = block ? '0 : mem_rdata;
   end
endmodule

// File: rtl/fg_guard_chk.sv
module fg_guard_chk #(
   parameter int                ADDR_W      = 32,
   parameter int                DATA_W      = 32,
   parameter logic [ADDR_W-1:0] FW_RAM_BASE = '0,
   parameter logic [ADDR_W-1:0] FW_RAM_SIZE = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_valid,
   input logic              cpu_fetch,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] mem_rdata,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              access_violation,
   input logic              en_q,
   input logic [ADDR_W-1:0] first_q,
   input logic [ADDR_W-1:0] last_q,
   input logic              trap_seen,
   input logic [2:0]        led_out
);
   logic [ADDR_W-1:0] fw_off;
   assign fw_off = cpu_addr - FW_RAM_BASE;

   p_enable_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> en_q);

   p_bounds_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> ($stable(first_q) && $stable(last_q)));

   p_region_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_fetch && en_q && cpu_addr >= first_q && cpu_addr <= last_q)
      |-> (cpu_rdata == '0));

   p_data_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && !cpu_fetch && !access_violation) |-> (cpu_rdata == mem_rdata));

   p_fw_fetch_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_fetch && cpu_addr >= FW_RAM_BASE && fw_off < FW_RAM_SIZE)
      |-> (cpu_rdata == '0));

   p_violation_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      access_violation |-> (cpu_valid && cpu_rdata == '0));

   p_trap_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_seen |=> trap_seen);

   p_trap_led_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_seen |-> (led_out[1:0] == 2'b00));
endmodule

bind fg_guard fg_guard_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .FW_RAM_BASE(FW_RAM_BASE), .FW_RAM_SIZE(FW_RAM_SIZE)
) i_fg_guard_chk (
   .clk(clk), .rst_n(rst_n),
   .cpu_valid(cpu_valid), .cpu_fetch(cpu_fetch), .cpu_addr(cpu_addr),
   .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata),
   .access_violation(access_violation),
   .en_q(en_q), .first_q(first_q), .last_q(last_q),
   .trap_seen(trap_seen), .led_out(led_out)
);

// File: tb/test_fg_guard.sv
`timescale 1ns/1ps
module test_fg_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_cs = 1'b0, reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        cpu_valid = 1'b0, cpu_fetch = 1'b0;
   logic [31:0] cpu_addr = '0, mem_rdata = '0, cpu_rdata;
   logic        access_violation;
   logic        cpu_trap = 1'b0;
   logic [2:0]  led_req = 3'b011, led_out;

   int vectors = 0, miscompares = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] d;
      logic        v;
      logic [31:0] r;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #5 clk = ~clk;

   fg_guard #(
      .FW_RAM_BASE(32'h0000_1000), .FW_RAM_SIZE(32'h0000_0100),
      .RAM_BASE(32'h4000_0000), .RAM_SIZE(32'h0000_1000),
      .RAM_WIN(32'h0001_0000), .FLASH_LOG2(3)
   ) i_fg_guard (.*);

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // driver: one bus cycle, expectations queued for the monitor
   task automatic cyc(input logic cs, we, input logic [7:0] ra, input logic [31:0] wd,
                      input logic val, fe, input logic [31:0] a, md,
                      input logic [31:0] ed, input logic ev, input logic [31:0] er,
                      input string tag);
      exp_t e;
      @(posedge clk); #1;
      reg_cs = cs; reg_we = we; reg_addr = ra; reg_wdata = wd;
      cpu_valid = val; cpu_fetch = fe; cpu_addr = a; mem_rdata = md;
      e.d = ed; e.v = ev; e.r = er; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic wr(input logic [7:0] ra, input logic [31:0] wd, input string tag);
      cyc(1, 1, ra, wd, 0, 0, 32'h0, 32'hA5A5_0001, 32'hA5A5_0001, 0, 32'h0, tag);
   endtask
   task automatic rd(input logic [7:0] ra, input logic [31:0] er, input string tag);
      cyc(1, 0, ra, 32'h0, 0, 0, 32'h0, 32'hA5A5_0002, 32'hA5A5_0002, 0, er, tag);
   endtask
   task automatic bus(input logic fe, input logic [31:0] a, md, ed, input logic ev, input string tag);
      cyc(0, 0, 8'h0, 32'h0, 1, fe, a, md, ed, ev, 32'h0, tag);
   endtask

   // monitor: pops and compares in the middle of each cycle
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(cpu_rdata == e.d, {e.tag, " cpu_rdata"}, cpu_rdata, e.d);
         check(access_violation == e.v, {e.tag, " violation"}, 32'(access_violation), 32'(e.v));
         check(reg_rdata == e.r, {e.tag, " reg_rdata"}, reg_rdata, e.r);
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(led_out == 3'b011, "R1 led passthrough", 32'(led_out), 32'h3);
      // R1 reset state
      rd(8'h60, 32'h0, "R1 ctrl");
      rd(8'h61, 32'h0, "R1 first");
      rd(8'h62, 32'h0, "R1 last");
      // R7 firmware window blocked before any enable
      bus(1, 32'h0000_1000, 32'h0000_0013, 32'h0, 0, "R7 fw fetch pre-enable");
      // R2 bounds
      wr(8'h61, 32'h4000_0200, "R2 wr first");
      wr(8'h62, 32'h4000_02FF, "R2 wr last");
      rd(8'h61, 32'h4000_0200, "R2 first");
      rd(8'h62, 32'h4000_02FF, "R2 last");
      rd(8'h63, 32'h0, "R2 unmapped");
      cyc(1, 1, 8'h61, 32'h0, 0, 0, 32'h0, 32'h7, 32'h7, 0, 32'h0, "R2 write gives zero rdata");
      wr(8'h61, 32'h4000_0200, "R2 restore first");
      // R5 before enable
      bus(1, 32'h4000_0200, 32'h1111_1111, 32'h1111_1111, 0, "R5 fetch pre-enable");
      // R3 enable
      wr(8'h60, 32'h1, "R3 set enable");
      rd(8'h60, 32'h1, "R3 ctrl");
      // R5 region
      bus(1, 32'h4000_0200, 32'h2222_2222, 32'h0, 0, "R5 first edge");
      bus(1, 32'h4000_02FF, 32'h3333_3333, 32'h0, 0, "R5 last edge");
      bus(1, 32'h4000_01FC, 32'h4444_4444, 32'h4444_4444, 0, "R5 below");
      bus(1, 32'h4000_0300, 32'h5555_5555, 32'h5555_5555, 0, "R5 above");
      // R6 data read in region
      bus(0, 32'h4000_0250, 32'h6666_6666, 32'h6666_6666, 0, "R6 data in region");
      // R3 cannot clear
      wr(8'h60, 32'h0, "R3 clear attempt");
      rd(8'h60, 32'h1, "R3 still set");
      // R4 bounds locked
      wr(8'h61, 32'h4000_0000, "R4 wr first");
      wr(8'h62, 32'h4000_0FFF, "R4 wr last");
      rd(8'h61, 32'h4000_0200, "R4 first kept");
      rd(8'h62, 32'h4000_02FF, "R4 last kept");
      bus(1, 32'h4000_0100, 32'h7777_7777, 32'h7777_7777, 0, "R4 old region unchanged");
      // R7 firmware window
      bus(1, 32'h0000_10FF, 32'h8888_8888, 32'h0, 0, "R7 fw top");
      bus(1, 32'h0000_1100, 32'h9999_9999, 32'h9999_9999, 0, "R7 past fw");
      bus(1, 32'h0000_0FFC, 32'h1212_1212, 32'h1212_1212, 0, "R7 below fw");
      bus(0, 32'h0000_1080, 32'hABAB_ABAB, 32'hABAB_ABAB, 0, "R7 fw data");
      // R8 out of range
      bus(0, 32'h4000_1000, 32'hCDCD_CDCD, 32'h0, 1, "R8 first oob data");
      bus(1, 32'h4000_FFFC, 32'hEFEF_EFEF, 32'h0, 1, "R8 last oob fetch");
      bus(0, 32'h4000_0FFC, 32'h3434_3434, 32'h3434_3434, 0, "R8 last ram word");
      bus(0, 32'h4001_0000, 32'h5656_5656, 32'h5656_5656, 0, "R8 past window");
      cyc(0, 0, 8'h0, 32'h0, 0, 0, 32'h4000_1000, 32'h7878_7878, 32'h7878_7878, 0, 32'h0,
          "R8 invalid no flag");
      @(posedge clk); #1;
      cpu_valid = 1'b0; reg_cs = 1'b0;
      wait (sb.size() == 0);
      // R9 trap
      @(negedge clk);
      check(led_out == 3'b011, "R9 pre-trap led", 32'(led_out), 32'h3);
      @(posedge clk); #1 cpu_trap = 1'b1;
      @(posedge clk); #1 cpu_trap = 1'b0; led_req = 3'b111;
      begin
         logic prev;
         int   n;
         @(negedge clk);
         check(led_out[1:0] == 2'b00, "R9 green/blue off", 32'(led_out), 32'h0);
         prev = led_out[2];
         while (led_out[2] == prev) begin @(negedge clk); end
         prev = led_out[2];
         n = 0;
         while (led_out[2] == prev && n < 100) begin @(negedge clk); n++; end
         check(n == 8, "R9 flash period", 32'(n), 32'd8);
         check(led_out[1:0] == 2'b00, "R9 override persists", 32'(led_out), 32'h0);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule